// File: doc/BRIEF.md
# E1 Frame Alignment Loss Detector

This block monitors an E1 stream whose frame position is already known and decides when that alignment has been lost. Once per frame it receives the timeslot-0 octet with a strobe, plus a flag saying whether the frame is one expected to carry the frame alignment signal (FAS) or the service word. Each word is judged correct or incorrect. Two independent runs of consecutive errors are kept: one for FAS words and one for service words.

When either run reaches the selected limit, a sticky loss-of-sync output is raised. The limit is three errors in normal mode and four in relaxed mode. In relaxed mode the service word track can also be switched off. The block performs no frame search and no CRC-4 multiframe handling. An external resync pulse, driven by whatever logic re-acquires the frame, clears the loss flag and both runs.

Bit 1 of the timeslot-0 octet is the first bit on the line and maps to `ts0_octet[7]`. Bit 8 maps to `ts0_octet[0]`.

Top module: `e1_sync_loss_mon`

## Requirements
- R1: A FAS word (`fas_frame`=1) is correct when `ts0_octet[6:0]` equals 7'b0011011. `ts0_octet[7]`, the Si/CRC bit, is ignored. Any other value in `ts0_octet[6:0]` is an error.
- R2: With `thr4_sel`=0, three consecutive incorrect FAS words raise `loss_sync`. Two do not.
- R3: With `thr4_sel`=0, three consecutive incorrect service words (`fas_frame`=0, error when `ts0_octet[6]`=0) raise `loss_sync`. `sw_chk_off` has no effect in this mode.
- R4: With `thr4_sel`=1, four consecutive incorrect FAS words, or four consecutive incorrect service words, raise `loss_sync`. Three do not.
- R5: With `thr4_sel`=1 and `sw_chk_off`=1, service words never contribute to loss, whatever their content.
- R6: A correct word clears only the run of its own kind. FAS errors and service word errors are never added together.
- R7: `loss_sync` is sticky. Once high, it stays high through any later words, correct or not, until a resync or reset.
- R8: A `resync` pulse clears `loss_sync` and both runs at the next clock edge. A strobe presented in the same cycle as `resync` is discarded.
- R9: A word is taken only on a cycle with `ts0_valid`=1. `loss_sync` goes high at the clock edge that samples the word completing the run.
- R10: While `rst_n` is low, `loss_sync` is 0 and both runs are empty. This holds even if loss had been declared before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts0_valid | input | 1 | Strobe: a timeslot-0 octet is present this cycle |
| ts0_octet | input | 8 | Timeslot-0 octet, line bit 1 in bit 7 |
| fas_frame | input | 1 | 1: frame carries FAS word; 0: frame carries service word |
| thr4_sel | input | 1 | 0: three-error limit; 1: four-error limit |
| sw_chk_off | input | 1 | Disables the service word track when `thr4_sel`=1 |
| resync | input | 1 | Clears loss flag and both error runs |
| loss_sync | output | 1 | Sticky loss-of-frame-alignment indication |

## Verification
The hardest situation to reach from the ports is the one where each track sits exactly one error short of the limit while the other track collects errors. Only this shows that the two runs are kept apart and that a correct word of one kind leaves the other run alone. The stimulus table interleaves FAS and service frames so that the combined error count passes the limit while neither track alone reaches it. A single correct word of the other kind then precedes the error that completes the run. A resync is also given together with a faulty FAS strobe. The following count confirms that the discarded error was not recorded.

// File: rtl/e1slm_pkg.sv
package e1slm_pkg;

    // Track indices: index 0 follows FAS words, index 1 follows service words
    localparam int TRK_FAS = 0;
    localparam int TRK_SVC = 1;
    localparam int NTRK    = 2;

    typedef struct packed {
        logic lost;
    } mon_state_t;

endpackage

// File: rtl/e1slm_word_check.sv
module e1slm_word_check
    import e1slm_pkg::*;
#(
    parameter logic [6:0] FAS_PAT = 7'b0011011
) (
    input  logic            ts0_valid,
    input  logic            fas_frame,
    input  logic [7:0]      ts0_octet,
    input  logic            svc_enable,
    input  logic            discard,
    output logic [NTRK-1:0] trk_hit,
    output logic [NTRK-1:0] trk_bad
);

    logic take;

    always_comb begin
        take             = ts0_valid && !discard;
        trk_hit          = '0;
        trk_bad          = '0;
        // FAS frame: line bits 2..8 must match the pattern, line bit 1 is free
        trk_hit[TRK_FAS] = take && fas_frame;
        trk_bad[TRK_FAS] = (ts0_octet[6:0] != FAS_PAT);
        // Service frame: only line bit 2 is examined, it must be one
        trk_hit[TRK_SVC] = take && !fas_frame && svc_enable;
        trk_bad[TRK_SVC] = !ts0_octet[6];
    end

endmodule

// File: rtl/e1slm_run_track.sv
module e1slm_run_track #(
    parameter int RUN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             freeze,
    input  logic             hit,
    input  logic             bad,
    input  logic [RUN_W-1:0] thresh,
    output logic [RUN_W-1:0] run,
    output logic             reach
);

    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    typedef struct packed {
        logic [RUN_W-1:0] cnt;
    } trk_state_t;

    trk_state_t       st_d, st_q;
    logic [RUN_W-1:0] inc;

    always_comb begin
        st_d  = st_q;
        reach = 1'b0;
        inc   = (st_q.cnt == RUN_MAX) ? st_q.cnt : st_q.cnt + 1'b1;
        if (clr) begin
            st_d.cnt = '0;
        end else if (hit && !freeze) begin
            if (bad) begin
                st_d.cnt = inc;
                reach    = (inc >= thresh);
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run = st_q.cnt;

endmodule

// File: rtl/e1_sync_loss_mon.sv
module e1_sync_loss_mon
    import e1slm_pkg::*;
#(
    parameter int         RUN_W    = 3,
    parameter int         LO_LIMIT = 3,
    parameter int         HI_LIMIT = 4,
    parameter logic [6:0] FAS_PAT  = 7'b0011011
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ts0_valid,
    input  logic [7:0] ts0_octet,
    input  logic       fas_frame,
    input  logic       thr4_sel,
    input  logic       sw_chk_off,
    input  logic       resync,
    output logic       loss_sync
);

    localparam logic [RUN_W-1:0] LO_T = LO_LIMIT[RUN_W-1:0];
    localparam logic [RUN_W-1:0] HI_T = HI_LIMIT[RUN_W-1:0];

    mon_state_t       mon_d, mon_q;
    logic [RUN_W-1:0] thresh;
    logic             svc_enable;
    logic [NTRK-1:0]  trk_hit, trk_bad, trk_clr, trk_reach;
    logic [RUN_W-1:0] trk_run [NTRK];
    logic [RUN_W-1:0] fas_run, sw_run;

    assign thresh     = thr4_sel ? HI_T : LO_T;
    // Disabling the service track is honoured only in the four-error mode
    assign svc_enable = !(thr4_sel && sw_chk_off);

    e1slm_word_check #(
        .FAS_PAT (FAS_PAT)
    ) u_check (
        .ts0_valid  (ts0_valid),
        .fas_frame  (fas_frame),
        .ts0_octet  (ts0_octet),
        .svc_enable (svc_enable),
        .discard    (resync),
        .trk_hit    (trk_hit),
        .trk_bad    (trk_bad)
    );

    always_comb begin
        trk_clr          = {NTRK{resync}};
        trk_clr[TRK_SVC] = resync || !svc_enable;
    end

    for (genvar g = 0; g < NTRK; g++) begin : g_trk
        e1slm_run_track #(
            .RUN_W (RUN_W)
        ) u_run (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (trk_clr[g]),
            .freeze (mon_q.lost),
            .hit    (trk_hit[g]),
            .bad    (trk_bad[g]),
            .thresh (thresh),
            .run    (trk_run[g]),
            .reach  (trk_reach[g])
        );
    end

    assign fas_run = trk_run[TRK_FAS];
    assign sw_run  = trk_run[TRK_SVC];

    always_comb begin
        mon_d = mon_q;
        if (resync) begin
            mon_d.lost = 1'b0;
        end else if (|trk_reach) begin
            mon_d.lost = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q <= '0;
        end else begin
            mon_q <= mon_d;
        end
    end

    assign loss_sync = mon_q.lost;

endmodule

// File: rtl/e1_sync_loss_mon_chk.sv
module e1_sync_loss_mon_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ts0_valid,
    input logic [7:0] ts0_octet,
    input logic       fas_frame,
    input logic       resync,
    input logic       loss_sync,
    input logic [2:0] fas_run,
    input logic [2:0] sw_run
);

    AST_RESYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> (!loss_sync && fas_run == 3'd0 && sw_run == 3'd0)); // R8

    AST_LOSS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (loss_sync && !resync) |=> loss_sync); // R7

    AST_RUN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (fas_run <= 3'd4 && sw_run <= 3'd4)); // R4

    AST_FAS_SPARES_SVC: assert property (@(posedge clk) disable iff (!rst_n)
        (ts0_valid && fas_frame && !resync) |=>
            (sw_run == $past(sw_run) || sw_run == 3'd0)); // R6

    AST_GOOD_FAS_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ts0_valid && fas_frame && ts0_octet[6:0] == 7'b0011011 && !loss_sync)
            |=> fas_run == 3'd0); // R1

    AST_LOSS_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loss_sync) |-> $past(ts0_valid)); // R9

endmodule

bind e1_sync_loss_mon e1_sync_loss_mon_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ts0_valid (ts0_valid),
    .ts0_octet (ts0_octet),
    .fas_frame (fas_frame),
    .resync    (resync),
    .loss_sync (loss_sync),
    .fas_run   (fas_run),
    .sw_run    (sw_run)
);

// File: tb/e1_sync_loss_mon_test.sv
module e1_sync_loss_mon_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV         = 36;

    // Vector layout: [13] resync, [12] valid, [11] fas_frame, [10:3] octet,
    // [2] thr4_sel, [1] sw_chk_off, [0] expected loss_sync after the edge
    localparam logic [13:0] VEC [NV] = '{
        {1'b0,1'b1,1'b1,8'h1B,1'b0,1'b0,1'b0}, // 0  R1 good FAS
        {1'b0,1'b1,1'b1,8'h1A,1'b0,1'b0,1'b0}, // 1  R2 fas err 1
        {1'b0,1'b1,1'b1,8'h1A,1'b0,1'b0,1'b0}, // 2  R2 fas err 2
        {1'b0,1'b1,1'b1,8'h9B,1'b0,1'b0,1'b0}, // 3  R1 Si set, still good
        {1'b0,1'b1,1'b1,8'h1A,1'b0,1'b0,1'b0}, // 4  R6 fas err 1
        {1'b0,1'b1,1'b1,8'h1A,1'b0,1'b0,1'b0}, // 5  R2 fas err 2
        {1'b0,1'b1,1'b0,8'hBF,1'b0,1'b0,1'b0}, // 6  R6 svc err 1
        {1'b0,1'b1,1'b0,8'hBF,1'b0,1'b0,1'b0}, // 7  R6 svc err 2, not summed
        {1'b0,1'b1,1'b0,8'hDF,1'b0,1'b0,1'b0}, // 8  R6 good svc
        {1'b0,1'b1,1'b1,8'h1A,1'b0,1'b0,1'b1}, // 9  R2 fas err 3 -> loss
        {1'b0,1'b1,1'b1,8'h1B,1'b0,1'b0,1'b1}, // 10 R7 sticky
        {1'b0,1'b0,1'b1,8'h1A,1'b0,1'b0,1'b1}, // 11 R7 idle
        {1'b1,1'b0,1'b1,8'h1B,1'b0,1'b0,1'b0}, // 12 R8 resync
        {1'b0,1'b1,1'b0,8'h00,1'b0,1'b1,1'b0}, // 13 R3 svc err 1
        {1'b0,1'b1,1'b0,8'h00,1'b0,1'b1,1'b0}, // 14 R3 svc err 2
        {1'b0,1'b1,1'b0,8'h00,1'b0,1'b1,1'b1}, // 15 R3 svc err 3 -> loss
        {1'b1,1'b0,1'b0,8'h00,1'b1,1'b0,1'b0}, // 16 R8 resync
        {1'b0,1'b1,1'b1,8'h5A,1'b1,1'b0,1'b0}, // 17 R4 fas err 1
        {1'b0,1'b1,1'b1,8'h1A,1'b1,1'b0,1'b0}, // 18 R4 fas err 2
        {1'b0,1'b1,1'b1,8'h1A,1'b1,1'b0,1'b0}, // 19 R4 fas err 3
        {1'b0,1'b0,1'b1,8'h1B,1'b1,1'b0,1'b0}, // 20 R9 no strobe, ignored
        {1'b0,1'b1,1'b1,8'h1A,1'b1,1'b0,1'b1}, // 21 R4 fas err 4 -> loss
        {1'b1,1'b0,1'b0,8'h00,1'b1,1'b0,1'b0}, // 22 R8 resync
        {1'b0,1'b1,1'b0,8'h00,1'b1,1'b1,1'b0}, // 23 R5 svc off
        {1'b0,1'b1,1'b0,8'h00,1'b1,1'b1,1'b0}, // 24 R5
        {1'b0,1'b1,1'b0,8'h00,1'b1,1'b1,1'b0}, // 25 R5
        {1'b0,1'b1,1'b0,8'h00,1'b1,1'b1,1'b0}, // 26 R5
        {1'b0,1'b1,1'b0,8'h00,1'b1,1'b0,1'b0}, // 27 R4 svc err 1
        {1'b0,1'b1,1'b0,8'h00,1'b1,1'b0,1'b0}, // 28 R4 svc err 2
        {1'b0,1'b1,1'b0,8'h00,1'b1,1'b0,1'b0}, // 29 R4 svc err 3
        {1'b0,1'b1,1'b0,8'h00,1'b1,1'b0,1'b1}, // 30 R4 svc err 4 -> loss
        {1'b1,1'b1,1'b1,8'h1A,1'b1,1'b0,1'b0}, // 31 R8 resync with strobe
        {1'b0,1'b1,1'b1,8'h1A,1'b1,1'b0,1'b0}, // 32 R8
        {1'b0,1'b1,1'b1,8'h1A,1'b1,1'b0,1'b0}, // 33 R8
        {1'b0,1'b1,1'b1,8'h1A,1'b1,1'b0,1'b0}, // 34 R8 only 3 counted
        {1'b0,1'b1,1'b1,8'h1A,1'b1,1'b0,1'b1}  // 35 R4 fourth -> loss
    };

    localparam int TAG [NV] = '{1,2,2,1,6,2,6,6,6,2,7,7,8,3,3,3,8,4,4,4,
                                9,4,8,5,5,5,5,4,4,4,4,8,8,8,8,4};

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ts0_valid;
    logic [7:0] ts0_octet;
    logic       fas_frame;
    logic       thr4_sel;
    logic       sw_chk_off;
    logic       resync;
    logic       loss_sync;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    e1_sync_loss_mon uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ts0_valid  (ts0_valid),
        .ts0_octet  (ts0_octet),
        .fas_frame  (fas_frame),
        .thr4_sel   (thr4_sel),
        .sw_chk_off (sw_chk_off),
        .resync     (resync),
        .loss_sync  (loss_sync)
    );

    task automatic check(input int tag, input logic exp_v, input string what);
        total++;
        if (loss_sync !== exp_v) begin
            bad++;
            $display("FAIL R%0d %s: loss_sync=%b expected=%b", tag, what, loss_sync, exp_v);
        end
    endtask

    task automatic apply(input logic [13:0] v);
        @(negedge clk);
        resync     = v[13];
        ts0_valid  = v[12];
        fas_frame  = v[11];
        ts0_octet  = v[10:3];
        thr4_sel   = v[2];
        sw_chk_off = v[1];
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ts0_valid = 1'b0; ts0_octet = 8'h00; fas_frame = 1'b0;
        thr4_sel = 1'b0; sw_chk_off = 1'b0; resync = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check(10, 1'b0, "in reset"); // R10
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(10, 1'b0, "after reset release"); // R10

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            check(TAG[i], VEC[i][0], $sformatf("vector %0d", i));
        end

        // Reset while loss is declared: R10
        apply({1'b0,1'b0,1'b1,8'h1B,1'b0,1'b0,1'b0});
        check(7, 1'b1, "still lost before reset"); // R7
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(10, 1'b0, "reset during loss"); // R10
        @(negedge clk);
        rst_n = 1'b1;
        apply({1'b0,1'b1,1'b1,8'h1A,1'b0,1'b0,1'b0});
        apply({1'b0,1'b1,1'b1,8'h1A,1'b0,1'b0,1'b0});
        check(10, 1'b0, "runs emptied by reset"); // R10
        apply({1'b0,1'b1,1'b1,8'h1A,1'b0,1'b0,1'b1});
        check(2, 1'b1, "third error after reset"); // R2

        apply({1'b0,1'b0,1'b1,8'h1B,1'b0,1'b0,1'b0});
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule